// File: doc/BRIEF.md
# Warp Vote and Ballot Unit

This block takes one boolean condition from each of the 32 lanes of a warp, together with a mask of the lanes that are running. It produces the ballot mask and three reductions over the running lanes in the same cycle. The reductions are "every one true", "at least one true" and "all the same". A single invert control can flip every lane's condition before any of these results is formed.

A two-bit select picks one of the three reductions to drive the destination predicate. The ballot mask is the value meant for the destination general register, and it is produced by the same operation as the predicate. Results appear one clock after an input strobe, with a matching output strobe. Between strobes the outputs hold their last values.

Top module: `warp_vote_unit`

## Requirements
- R1: When `pred_invert` is 1, each lane's condition is taken as the inverse of `lane_pred` before the ballot and all three reductions are formed. When it is 0, the condition is `lane_pred` unchanged.
- R2: `ballot` bit i is 1 exactly when lane i is active (`lane_active` bit i is 1) and its condition is true. An inactive lane always gives 0.
- R3: `vote_all` is 1 when no active lane has a false condition.
- R4: `vote_any` is 1 when at least one active lane has a true condition.
- R5: `vote_eq` is 1 when the active lanes all hold the same condition, either all true or all false.
- R6: `vote_result` follows `red_sel`. The encodings are: 0 gives the value of `vote_all`, 1 gives `vote_any`, 2 gives `vote_eq`. The unused code 3 behaves as 0 and gives `vote_all`.
- R7: When `lane_active` is all zero, `vote_all` is 1, `vote_eq` is 1, `vote_any` is 0 and `ballot` is 0.
- R8: A strobe on `in_valid` at a clock edge gives `out_valid` high and updated results after that edge. Without a strobe, `out_valid` is low after the edge and the result outputs keep their previous values.
- R9: While `rst_n` is low, `out_valid`, `ballot`, `vote_all`, `vote_any`, `vote_eq` and `vote_result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; samples the operands |
| lane_pred | input | 32 | Per-lane source condition |
| lane_active | input | 32 | Per-lane running mask |
| pred_invert | input | 1 | Flip every lane condition first |
| red_sel | input | 2 | Reduction choice for the predicate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| ballot | output | 32 | Mask of active lanes whose condition is true |
| vote_all | output | 1 | All active lanes true |
| vote_any | output | 1 | Some active lane true |
| vote_eq | output | 1 | Active lanes unanimous |
| vote_result | output | 1 | Selected reduction for the destination predicate |

## Verification
The assertions assume that `in_valid` is never unknown after reset. They also assume that each strobe's operands are steady around the sampling edge, since the output-stage properties compare the registered results with the strobe of the cycle before.

The stimulus changes all inputs one time unit after a rising edge, so every sampled value is stable. It drives known values on every input from time zero, including between strobes. The idle cycles carry deliberately different operands, so the hold property and the bench's check of stable outputs see inputs that would change the result if they were wrongly captured.

// File: rtl/warp_vote_pkg.sv
package warp_vote_pkg;

  typedef enum logic [1:0] {
    RED_ALL  = 2'd0,
    RED_ANY  = 2'd1,
    RED_EQ   = 2'd2,
    RED_RSVD = 2'd3
  } red_sel_e;

  typedef struct packed {
    logic all_ok;
    logic any_ok;
    logic eq_ok;
  } red_flags_t;

  // Unused code maps onto the all-true reduction.
  function automatic red_sel_e legal_sel(input logic [1:0] raw);
    red_sel_e s;
    case (raw)
      2'd1:    s = RED_ANY;
      2'd2:    s = RED_EQ;
      default: s = RED_ALL;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vote_lane_cond.sv
module vote_lane_cond #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] active_i,
  input  logic             invert_i,
  output logic [LANES-1:0] true_mask_o,
  output logic [LANES-1:0] false_mask_o
);

  // Per-lane conditioning: inversion first, then gating by the running mask.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic cond;
    assign cond            = pred_i[g] ^ invert_i;
    assign true_mask_o[g]  = cond & active_i[g];
    assign false_mask_o[g] = ~cond & active_i[g];
  end

endmodule

// File: rtl/vote_reduce.sv
module vote_reduce
  import warp_vote_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [LANES-1:0] active_i,
  input  logic [LANES-1:0] true_mask_i,
  input  logic [LANES-1:0] false_mask_i,
  output red_flags_t       flags_o
);

  logic none_false;
  logic some_true;

  always_comb begin
    none_false     = ~|false_mask_i;
    some_true      = |true_mask_i;
    flags_o.all_ok = none_false;
    flags_o.any_ok = some_true;
    flags_o.eq_ok  = none_false | ~some_true;
  end

  AST_BALLOT_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |-> ((true_mask_i & ~active_i) == '0)); // R2

  AST_ALL_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && flags_o.all_ok) |-> (true_mask_i == active_i)); // R3

  AST_ANY_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && flags_o.any_ok) |-> ($countones(true_mask_i) > 0)); // R4

  AST_EMPTY_WARP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && active_i == '0) |-> (flags_o.all_ok && flags_o.eq_ok && !flags_o.any_ok)); // R7

endmodule

// File: rtl/vote_out_stage.sv
module vote_out_stage
  import warp_vote_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [1:0]       sel_i,
  input  logic [LANES-1:0] ballot_i,
  input  red_flags_t       flags_i,
  output logic             out_valid_o,
  output logic [LANES-1:0] ballot_o,
  output red_flags_t       flags_o,
  output logic             result_o
);

  red_sel_e         sel_legal;
  logic             pick_d;
  logic [LANES-1:0] ballot_d;
  red_flags_t       flags_d;
  logic             result_d;
  red_sel_e         sel_q;
  red_sel_e         sel_d;

  always_comb begin
    sel_legal = legal_sel(sel_i);
    case (sel_legal)
      RED_ANY: pick_d = flags_i.any_ok;
      RED_EQ:  pick_d = flags_i.eq_ok;
      default: pick_d = flags_i.all_ok;
    endcase
    ballot_d = ballot_o;
    flags_d  = flags_o;
    result_d = result_o;
    sel_d    = sel_q;
    if (in_valid_i) begin
      ballot_d = ballot_i;
      flags_d  = flags_i;
      result_d = pick_d;
      sel_d    = sel_legal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      ballot_o    <= '0;
      flags_o     <= '0;
      result_o    <= 1'b0;
      sel_q       <= RED_ALL;
    end else begin
      out_valid_o <= in_valid_i;
      ballot_o    <= ballot_d;
      flags_o     <= flags_d;
      result_o    <= result_d;
      sel_q       <= sel_d;
    end
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o); // R8

  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(ballot_o) && $stable(result_o))); // R8

  AST_SEL_ANY_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && sel_q == RED_ANY) |-> (result_o == flags_o.any_ok)); // R6

  AST_SEL_EQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && sel_q == RED_EQ) |-> (result_o == flags_o.eq_ok)); // R6

  AST_SEL_ALL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && sel_q == RED_ALL) |-> (result_o == flags_o.all_ok)); // R6

endmodule

// File: rtl/warp_vote_unit.sv
module warp_vote_unit
  import warp_vote_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LANES-1:0] lane_pred,
  input  logic [LANES-1:0] lane_active,
  input  logic             pred_invert,
  input  logic [1:0]       red_sel,
  output logic             out_valid,
  output logic [LANES-1:0] ballot,
  output logic             vote_all,
  output logic             vote_any,
  output logic             vote_eq,
  output logic             vote_result
);

  logic [LANES-1:0] true_mask;
  logic [LANES-1:0] false_mask;
  red_flags_t       flags_c;
  red_flags_t       flags_q;

  vote_lane_cond #(.LANES(LANES)) u_cond (
    .pred_i       (lane_pred),
    .active_i     (lane_active),
    .invert_i     (pred_invert),
    .true_mask_o  (true_mask),
    .false_mask_o (false_mask)
  );

  vote_reduce #(.LANES(LANES)) u_red (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid),
    .active_i     (lane_active),
    .true_mask_i  (true_mask),
    .false_mask_i (false_mask),
    .flags_o      (flags_c)
  );

  vote_out_stage #(.LANES(LANES)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .sel_i       (red_sel),
    .ballot_i    (true_mask),
    .flags_i     (flags_c),
    .out_valid_o (out_valid),
    .ballot_o    (ballot),
    .flags_o     (flags_q),
    .result_o    (vote_result)
  );

  assign vote_all = flags_q.all_ok;
  assign vote_any = flags_q.any_ok;
  assign vote_eq  = flags_q.eq_ok;

  AST_ALL_AND_ANY_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && vote_all && vote_any) |-> vote_eq); // R5

endmodule

// File: tb/sim_warp_vote_unit.sv
module sim_warp_vote_unit;

  localparam int LANES = 32;

  typedef struct {
    logic [LANES-1:0] ballot;
    logic             all_ok;
    logic             any_ok;
    logic             eq_ok;
    logic             result;
    string            scen;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [LANES-1:0] lane_pred;
  logic [LANES-1:0] lane_active;
  logic             pred_invert;
  logic [1:0]       red_sel;
  logic             out_valid;
  logic [LANES-1:0] ballot;
  logic             vote_all;
  logic             vote_any;
  logic             vote_eq;
  logic             vote_result;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  logic [LANES-1:0] last_ballot = '0;
  logic             last_result = 1'b0;

  warp_vote_unit #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_pred(lane_pred),
    .lane_active(lane_active), .pred_invert(pred_invert), .red_sel(red_sel),
    .out_valid(out_valid), .ballot(ballot), .vote_all(vote_all),
    .vote_any(vote_any), .vote_eq(vote_eq), .vote_result(vote_result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [LANES-1:0] act,
                       input logic [LANES-1:0] expv, input string scen);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, scen, act, expv);
    end
  endtask

  // Driver: computes the expected item from the requirements and queues it.
  task automatic drive(input logic [LANES-1:0] p, input logic [LANES-1:0] a,
                       input logic inv, input logic [1:0] sel, input string scen);
    exp_t e;
    int   nt = 0;
    int   nf = 0;
    for (int i = 0; i < LANES; i++) begin
      logic c;
      c = p[i] ^ inv;                       // R1
      e.ballot[i] = c & a[i];               // R2
      if (a[i] && c)  nt++;
      if (a[i] && !c) nf++;
    end
    e.all_ok = (nf == 0);                   // R3
    e.any_ok = (nt > 0);                    // R4
    e.eq_ok  = (nf == 0) || (nt == 0);      // R5
    case (sel)                              // R6
      2'd1:    e.result = e.any_ok;
      2'd2:    e.result = e.eq_ok;
      default: e.result = e.all_ok;
    endcase
    e.scen = scen;
    exp_q.push_back(e);
    @(posedge clk); #1;
    in_valid    = 1'b1;
    lane_pred   = p;
    lane_active = a;
    pred_invert = inv;
    red_sel     = sel;
    @(posedge clk); #1;
    in_valid    = 1'b0;
    lane_pred   = ~p;
    lane_active = ~a;
    pred_invert = ~inv;
    red_sel     = sel + 2'd1;
  endtask

  // Monitor: samples away from the active edge.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", 32'(out_valid), 32'd0, "unexpected strobe");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(ballot == e.ballot, "R2", ballot, e.ballot, e.scen);
        check(vote_all == e.all_ok, "R3", 32'(vote_all), 32'(e.all_ok), e.scen);
        check(vote_any == e.any_ok, "R4", 32'(vote_any), 32'(e.any_ok), e.scen);
        check(vote_eq == e.eq_ok, "R5", 32'(vote_eq), 32'(e.eq_ok), e.scen);
        check(vote_result == e.result, "R6", 32'(vote_result), 32'(e.result), e.scen);
        last_ballot = e.ballot;
        last_result = e.result;
      end
    end else if (rst_n) begin
      // R8: idle cycle keeps the previous results.
      check(ballot == last_ballot, "R8", ballot, last_ballot, "hold ballot");
      check(vote_result == last_result, "R8", 32'(vote_result), 32'(last_result), "hold result");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    lane_pred   = '0;
    lane_active = '0;
    pred_invert = 1'b0;
    red_sel     = 2'd0;
    repeat (3) @(posedge clk);
    #2;
    // R9: reset state
    check(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0, "reset valid");
    check(ballot == '0, "R9", ballot, '0, "reset ballot");
    check({vote_all, vote_any, vote_eq, vote_result} == 4'b0, "R9",
          32'({vote_all, vote_any, vote_eq, vote_result}), 32'd0, "reset flags");
    @(negedge clk);
    rst_n = 1'b1;

    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd0, "R3 all true");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 2'd1, "R4 none true");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 2'd2, "R5 all false unanimous");
    drive(32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 2'd1, "R4 edge lanes");
    drive(32'h0F0F_00FF, 32'h0F0F_00FF, 1'b0, 2'd0, "R3 true on active only");
    drive(32'hFFFF_FFFF, 32'h0000_F000, 1'b0, 2'd2, "R2 inactive masked");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 2'd0, "R1 inverted all true");
    drive(32'h1234_5678, 32'hFF00_FF00, 1'b1, 2'd1, "R1 inverted mixed");
    drive(32'h1234_5678, 32'h0000_0000, 1'b0, 2'd0, "R7 empty sel all");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 2'd1, "R7 empty sel any");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 2'd2, "R7 empty sel eq");
    drive(32'h0000_0001, 32'h0000_0003, 1'b0, 2'd3, "R6 code 3 falls back");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd3, "R6 code 3 all true");
    drive(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 2'd2, "R5 one dissenter");
    for (int k = 0; k < 40; k++) begin
      logic [LANES-1:0] rp;
      logic [LANES-1:0] ra;
      rp = $urandom();
      ra = (k % 4 == 0) ? 32'hFFFF_FFFF : 32'($urandom());
      if (k % 5 == 0) rp = ra;
      drive(rp, ra, k[0], k[2:1], "mixed pattern");
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R8", 32'(exp_q.size()), 32'd0, "all results seen");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule